// File: doc/BRIEF.md
# Token-Ring MSI Cache Controller

This block is the private cache controller for one processor in a multiprocessor ring. It keeps a small direct-mapped line store coherent under the MSI protocol. It serves loads and stores from its CPU port. Messages arrive on a unidirectional point-to-point ring and leave on it again. Each message is held in an input FIFO, examined, and sent on through an output FIFO. A lone token circulates on the ring. A controller puts a new request on the ring only while it holds that token, so requests from all processors are ordered one at a time.

A CPU access that hits completes locally. A load hits on a Shared or Modified line, and a store hits only on a Modified line. A miss waits for the token and then sends a Read or a Write around the whole ring. Every peer snoops the request as it passes: it attaches its copy of the data, and it downgrades or invalidates its own line. The request comes back to its sender with the data. The sender installs the line, answers the CPU and sends a WriteBack so the memory node is updated. When the WriteBack completes its own lap, the sender releases the token. A three-valued pending register tracks these phases: idle, request out, writeback out.

Top module: `ring_msi_ctrl`

## Requirements
- R1: After reset, cpu_req_ready is 1, cpu_rsp_valid is 0, ring_out_valid is 0, pending is idle and every line is Invalid.
- R2: The controller places its own Read or Write on the ring only in the cycle it consumes an arriving token (op 3), and only if a CPU miss is waiting and pending is idle. That token is then held. In every other case an arriving token is forwarded unchanged.
- R3: A Read, Write or WriteBack from another node whose line is absent here (Invalid, or a tag mismatch) is forwarded with every field unchanged. A passing WriteBack is always forwarded unchanged.
- R4: When its own Read (op 0, src = MY_ID) returns while a request is out, the controller installs the carried data as Shared and returns that data to the CPU. It also sends a WriteBack (op 2) for the same address with that data, dv = 1 and src = MY_ID.
- R5: When its own Write (op 1) returns, the controller installs the CPU store data as Modified and answers the CPU. It sends a WriteBack carrying the stored data.
- R6: A passing foreign Write that hits a Shared or Modified line has the line data attached (dv = 1), and the line becomes Invalid.
- R7: A passing foreign Read that hits a Modified line has the line data attached, and the line becomes Shared. A passing foreign Read that hits a Shared line also gets the data attached, and the line stays Shared.
- R8: When its own WriteBack returns while the writeback phase is active, pending returns to idle and a token message (op 3, src = MY_ID) is sent.
- R9: With pending idle, a load hit or a store hit to a Modified line produces cpu_rsp_valid on the edge after the request is taken. A load returns the line data and a store updates the line. Neither produces any ring traffic.
- R10: cpu_req_ready stays 0 while a CPU request is held or while pending is not idle.
- R11: No ring message is dropped or reordered. ring_in_ready falls when the input FIFO is full, and messages wait while the output FIFO is full.
- R12: Opcodes are Read 0, Write 1, WriteBack 2 and token 3. The line index is the low IDX_W address bits and the tag is the rest.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req_valid | input | 1 | CPU request present |
| cpu_req_ready | output | 1 | Controller can take a CPU request |
| cpu_req_write | input | 1 | 1 = store, 0 = load |
| cpu_req_addr | input | ADDR_W | Word address |
| cpu_req_wdata | input | DATA_W | Store data |
| cpu_rsp_valid | output | 1 | One-cycle response pulse |
| cpu_rsp_rdata | output | DATA_W | Load data, or the stored value for stores |
| ring_in_valid | input | 1 | Upstream message present |
| ring_in_ready | output | 1 | Input FIFO has room |
| ring_in_op | input | 2 | Opcode of incoming message |
| ring_in_addr | input | ADDR_W | Address of incoming message |
| ring_in_data | input | DATA_W | Data of incoming message |
| ring_in_dv | input | 1 | Data field is meaningful |
| ring_in_src | input | ID_W | Originating node id |
| ring_out_valid | output | 1 | Downstream message present |
| ring_out_ready | input | 1 | Downstream accepts the message |
| ring_out_op | output | 2 | Opcode of outgoing message |
| ring_out_addr | output | ADDR_W | Address of outgoing message |
| ring_out_data | output | DATA_W | Data of outgoing message |
| ring_out_dv | output | 1 | Data field is meaningful |
| ring_out_src | output | ID_W | Originating node id |

## Verification
A ring message taken on edge k is handled on edge k+1. Its forwarded or replacement form, any CPU response it causes, and its effect on the line are all visible just after that edge. A CPU request taken on edge k is evaluated on edge k+1, so a hit answers then. The bench drives and samples on falling edges. It polls for each ring output and response within a short bound, and it reads the response in the same half cycle as the WriteBack that comes with it. Absence is shown by watching ring_out_valid and cpu_rsp_valid stay low over several cycles. An invalidation is shown by a later CPU load that fails to hit.

// File: rtl/msc_pkg.sv
package msc_pkg;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 16;
    localparam int ID_W   = 3;

    typedef enum logic [1:0] {
        OP_RD  = 2'd0,
        OP_WR  = 2'd1,
        OP_WB  = 2'd2,
        OP_TOK = 2'd3
    } ring_op_e;

    typedef enum logic [1:0] {
        LN_I = 2'd0,
        LN_S = 2'd1,
        LN_M = 2'd2
    } line_st_e;

    typedef struct packed {
        ring_op_e            op;
        logic [ADDR_W-1:0]   addr;
        logic [DATA_W-1:0]   data;
        logic                dv;
        logic [ID_W-1:0]     src;
    } ring_msg_t;

    localparam int MSG_W = $bits(ring_msg_t);
endpackage

// File: rtl/msc_fifo.sv
module msc_fifo #(
    parameter int W  = 8,
    parameter int AW = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         full,
    output logic         empty
);
    localparam int DEPTH = 1 << AW;

    logic [W-1:0]  mem_q [DEPTH];
    logic [AW-1:0] wp_q, wp_d, rp_q, rp_d;
    logic [AW:0]   cnt_q, cnt_d;

    always_comb begin
        wp_d  = push ? wp_q + AW'(1) : wp_q;
        rp_d  = pop  ? rp_q + AW'(1) : rp_q;
        cnt_d = cnt_q;
        if (push && !pop) cnt_d = cnt_q + (AW+1)'(1);
        if (pop && !push) cnt_d = cnt_q - (AW+1)'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            wp_q  <= wp_d;
            rp_q  <= rp_d;
            cnt_q <= cnt_d;
        end
    end

    always_ff @(posedge clk) begin
        if (push) mem_q[wp_q] <= din;
    end

    assign dout  = mem_q[rp_q];
    assign full  = (cnt_q == (AW+1)'(DEPTH));
    assign empty = (cnt_q == '0);

    // R11: storage never overruns or underruns
    a_r11_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    a_r11_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
endmodule

// File: rtl/msc_lines.sv
module msc_lines
    import msc_pkg::*;
#(
    parameter int IDX_W = 2,
    parameter int TAG_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  idx,
    output line_st_e          rd_st,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  line_st_e          wr_st,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [DATA_W-1:0] wr_data
);
    localparam int LINES = 1 << IDX_W;

    line_st_e          st_q  [LINES];
    logic [TAG_W-1:0]  tag_q [LINES];
    logic [DATA_W-1:0] dat_q [LINES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < LINES; i++) st_q[i] <= LN_I;
        end else if (wr_en) begin
            st_q[idx] <= wr_st;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[idx] <= wr_tag;
            dat_q[idx] <= wr_data;
        end
    end

    assign rd_st   = st_q[idx];
    assign rd_tag  = tag_q[idx];
    assign rd_data = dat_q[idx];
endmodule

// File: rtl/ring_msi_ctrl.sv
module ring_msi_ctrl
    import msc_pkg::*;
#(
    parameter logic [ID_W-1:0] MY_ID   = 3'd1,
    parameter int              IDX_W   = 2,
    parameter int              FIFO_AW = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req_valid,
    output logic              cpu_req_ready,
    input  logic              cpu_req_write,
    input  logic [ADDR_W-1:0] cpu_req_addr,
    input  logic [DATA_W-1:0] cpu_req_wdata,
    output logic              cpu_rsp_valid,
    output logic [DATA_W-1:0] cpu_rsp_rdata,
    input  logic              ring_in_valid,
    output logic              ring_in_ready,
    input  logic [1:0]        ring_in_op,
    input  logic [ADDR_W-1:0] ring_in_addr,
    input  logic [DATA_W-1:0] ring_in_data,
    input  logic              ring_in_dv,
    input  logic [ID_W-1:0]   ring_in_src,
    output logic              ring_out_valid,
    input  logic              ring_out_ready,
    output logic [1:0]        ring_out_op,
    output logic [ADDR_W-1:0] ring_out_addr,
    output logic [DATA_W-1:0] ring_out_data,
    output logic              ring_out_dv,
    output logic [ID_W-1:0]   ring_out_src
);
    localparam int         TAG_W     = ADDR_W - IDX_W;
    localparam logic [1:0] PEND_IDLE = 2'd0;
    localparam logic [1:0] PEND_REQ  = 2'd1;
    localparam logic [1:0] PEND_WB   = 2'd2;

    typedef struct packed {
        logic              slot_v;
        logic              slot_wr;
        logic              slot_miss;
        logic [ADDR_W-1:0] slot_addr;
        logic [DATA_W-1:0] slot_wdata;
        logic [1:0]        pend;
        logic              tok;
        logic              rsp_v;
        logic [DATA_W-1:0] rsp_data;
    } ctl_s;

    ctl_s s_q, s_d;

    ring_msg_t in_din, in_head, out_msg, out_head;
    logic      in_push, in_pop, in_full, in_empty;
    logic      out_push, out_pop, out_full, out_empty;

    // ring edge
    assign in_din        = '{op: ring_op_e'(ring_in_op), addr: ring_in_addr,
                             data: ring_in_data, dv: ring_in_dv, src: ring_in_src};
    assign ring_in_ready = !in_full;
    assign in_push       = ring_in_valid && !in_full;

    assign ring_out_valid = !out_empty;
    assign out_pop        = ring_out_valid && ring_out_ready;
    assign ring_out_op    = out_head.op;
    assign ring_out_addr  = out_head.addr;
    assign ring_out_data  = out_head.data;
    assign ring_out_dv    = out_head.dv;
    assign ring_out_src   = out_head.src;

    msc_fifo #(.W(MSG_W), .AW(FIFO_AW)) u_in_q (
        .clk(clk), .rst_n(rst_n), .push(in_push), .din(in_din),
        .pop(in_pop), .dout(in_head), .full(in_full), .empty(in_empty));

    msc_fifo #(.W(MSG_W), .AW(FIFO_AW)) u_out_q (
        .clk(clk), .rst_n(rst_n), .push(out_push), .din(out_msg),
        .pop(out_pop), .dout(out_head), .full(out_full), .empty(out_empty));

    // line store
    logic              ring_go;
    logic [ADDR_W-1:0] look_addr;
    logic [IDX_W-1:0]  look_idx;
    logic [TAG_W-1:0]  look_tag;
    line_st_e          ln_st;
    logic [TAG_W-1:0]  ln_tag;
    logic [DATA_W-1:0] ln_data;
    logic              ln_hit;
    logic              wr_en;
    line_st_e          wr_st;
    logic [DATA_W-1:0] wr_data;
    logic              own_fill, own_wb;

    assign ring_go   = !in_empty && !out_full;
    assign look_addr = ring_go ? in_head.addr : s_q.slot_addr;
    assign look_idx  = look_addr[IDX_W-1:0];
    assign look_tag  = look_addr[ADDR_W-1:IDX_W];
    assign ln_hit    = (ln_st != LN_I) && (ln_tag == look_tag);

    msc_lines #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_lines (
        .clk(clk), .rst_n(rst_n), .idx(look_idx),
        .rd_st(ln_st), .rd_tag(ln_tag), .rd_data(ln_data),
        .wr_en(wr_en), .wr_st(wr_st), .wr_tag(look_tag), .wr_data(wr_data));

    assign own_fill = (in_head.src == MY_ID) && (s_q.pend == PEND_REQ)
                    && ((in_head.op == OP_RD) || (in_head.op == OP_WR));
    assign own_wb   = (in_head.src == MY_ID) && (s_q.pend == PEND_WB)
                    && (in_head.op == OP_WB);

    assign cpu_req_ready = !s_q.slot_v && (s_q.pend == PEND_IDLE);
    assign cpu_rsp_valid = s_q.rsp_v;
    assign cpu_rsp_rdata = s_q.rsp_data;

    always_comb begin
        s_d      = s_q;
        s_d.rsp_v = 1'b0;
        in_pop   = 1'b0;
        out_push = 1'b0;
        out_msg  = in_head;
        wr_en    = 1'b0;
        wr_st    = ln_st;
        wr_data  = ln_data;

        if (ring_go) begin
            in_pop   = 1'b1;
            out_push = 1'b1;
            if (in_head.op == OP_TOK) begin
                if (s_q.slot_v && s_q.slot_miss && (s_q.pend == PEND_IDLE)) begin
                    out_msg  = '{op: (s_q.slot_wr ? OP_WR : OP_RD), addr: s_q.slot_addr,
                                 data: '0, dv: 1'b0, src: MY_ID};
                    s_d.tok  = 1'b1;
                    s_d.pend = PEND_REQ;
                end
            end else if (own_fill) begin
                wr_en   = 1'b1;
                wr_st   = (in_head.op == OP_WR) ? LN_M : LN_S;
                wr_data = (in_head.op == OP_WR) ? s_q.slot_wdata : in_head.data;
                out_msg = '{op: OP_WB, addr: in_head.addr, data: wr_data,
                            dv: 1'b1, src: MY_ID};
                s_d.pend      = PEND_WB;
                s_d.rsp_v     = 1'b1;
                s_d.rsp_data  = wr_data;
                s_d.slot_v    = 1'b0;
                s_d.slot_miss = 1'b0;
            end else if (own_wb) begin
                out_msg  = '{op: OP_TOK, addr: '0, data: '0, dv: 1'b0, src: MY_ID};
                s_d.pend = PEND_IDLE;
                s_d.tok  = 1'b0;
            end else if (ln_hit && (in_head.op != OP_WB)) begin
                out_msg.data = ln_data;
                out_msg.dv   = 1'b1;
                if (in_head.op == OP_WR) begin
                    wr_en = 1'b1;
                    wr_st = LN_I;
                end else if (ln_st == LN_M) begin
                    wr_en = 1'b1;
                    wr_st = LN_S;
                end
            end
        end else if (s_q.slot_v && !s_q.slot_miss && (s_q.pend == PEND_IDLE)) begin
            if (!s_q.slot_wr && ln_hit) begin
                s_d.rsp_v    = 1'b1;
                s_d.rsp_data = ln_data;
                s_d.slot_v   = 1'b0;
            end else if (s_q.slot_wr && ln_hit && (ln_st == LN_M)) begin
                wr_en        = 1'b1;
                wr_st        = LN_M;
                wr_data      = s_q.slot_wdata;
                s_d.rsp_v    = 1'b1;
                s_d.rsp_data = s_q.slot_wdata;
                s_d.slot_v   = 1'b0;
            end else begin
                s_d.slot_miss = 1'b1;
            end
        end

        if (cpu_req_valid && cpu_req_ready) begin
            s_d.slot_v     = 1'b1;
            s_d.slot_wr    = cpu_req_write;
            s_d.slot_miss  = 1'b0;
            s_d.slot_addr  = cpu_req_addr;
            s_d.slot_wdata = cpu_req_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R2: own requests leave only in exchange for a consumed token
    a_r2_token_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (out_push && (out_msg.src == MY_ID) && ((out_msg.op == OP_RD) || (out_msg.op == OP_WR)))
        |-> (in_pop && (in_head.op == OP_TOK)));
    // R2: token is held for the whole outstanding transaction
    a_r2_token_held: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.pend != PEND_IDLE) |-> s_q.tok);
    // R8: pending only leaves the writeback phase on its own returning WriteBack
    a_r8_release: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(s_q.pend) == PEND_WB) && (s_q.pend == PEND_IDLE))
        |-> $past(in_pop && (in_head.op == OP_WB)));
    a_r8_pend_legal: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.pend != 2'd3);
    // R10: no new CPU request accepted while a transaction is open
    a_r10_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.pend != PEND_IDLE) |-> !cpu_req_ready);
    // R11: every consumed ring message produces exactly one outgoing message
    a_r11_conserve: assert property (@(posedge clk) disable iff (!rst_n)
        in_pop |-> (out_push && !out_full));
endmodule

// File: tb/ring_msi_ctrl_bench.sv
module ring_msi_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;
    localparam logic [2:0] ME    = 3'd1;
    localparam logic [2:0] OTHER = 3'd3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req_valid = 1'b0, cpu_req_write = 1'b0;
    logic [7:0]  cpu_req_addr = '0;
    logic [15:0] cpu_req_wdata = '0;
    logic        cpu_req_ready, cpu_rsp_valid;
    logic [15:0] cpu_rsp_rdata;
    logic        ring_in_valid = 1'b0, ring_in_dv = 1'b0;
    logic [1:0]  ring_in_op = '0;
    logic [7:0]  ring_in_addr = '0;
    logic [15:0] ring_in_data = '0;
    logic [2:0]  ring_in_src = '0;
    logic        ring_in_ready, ring_out_valid, ring_out_dv;
    logic        ring_out_ready = 1'b0;
    logic [1:0]  ring_out_op;
    logic [7:0]  ring_out_addr;
    logic [15:0] ring_out_data;
    logic [2:0]  ring_out_src;

    int n_chk = 0;
    int n_fail = 0;
    logic done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ring_msi_ctrl #(.MY_ID(ME)) u_ring_msi_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
        .cpu_req_write(cpu_req_write), .cpu_req_addr(cpu_req_addr),
        .cpu_req_wdata(cpu_req_wdata), .cpu_rsp_valid(cpu_rsp_valid),
        .cpu_rsp_rdata(cpu_rsp_rdata),
        .ring_in_valid(ring_in_valid), .ring_in_ready(ring_in_ready),
        .ring_in_op(ring_in_op), .ring_in_addr(ring_in_addr),
        .ring_in_data(ring_in_data), .ring_in_dv(ring_in_dv), .ring_in_src(ring_in_src),
        .ring_out_valid(ring_out_valid), .ring_out_ready(ring_out_ready),
        .ring_out_op(ring_out_op), .ring_out_addr(ring_out_addr),
        .ring_out_data(ring_out_data), .ring_out_dv(ring_out_dv), .ring_out_src(ring_out_src));

    typedef struct packed {
        logic [1:0]  op;
        logic [7:0]  addr;
        logic [15:0] din;
        logic        dvin;
        logic [15:0] exp_data;
        logic        exp_dv;
        logic [3:0]  req;
    } vec_t;

    // snoop vectors from OTHER, applied while line 0x10 is Modified holding 5555
    localparam vec_t VEC [9] = '{
        '{2'd0, 8'h21, 16'h0BAD, 1'b0, 16'h0BAD, 1'b0, 4'd3},  // R3 read, line absent
        '{2'd2, 8'h22, 16'h7777, 1'b1, 16'h7777, 1'b1, 4'd3},  // R3 writeback passes
        '{2'd0, 8'h14, 16'h0BAD, 1'b0, 16'h0BAD, 1'b0, 4'd7},  // R7 tag miss
        '{2'd0, 8'h10, 16'h0BAD, 1'b0, 16'h5555, 1'b1, 4'd7},  // R7 M read hit -> S
        '{2'd1, 8'h14, 16'h0BAD, 1'b0, 16'h0BAD, 1'b0, 4'd6},  // R6 tag miss
        '{2'd0, 8'h10, 16'h0BAD, 1'b0, 16'h5555, 1'b1, 4'd7},  // R7 S read hit stays S
        '{2'd1, 8'h10, 16'h0BAD, 1'b0, 16'h5555, 1'b1, 4'd6},  // R6 write hit -> I
        '{2'd0, 8'h10, 16'h0BAD, 1'b0, 16'h0BAD, 1'b0, 4'd6},  // R6 now invalid
        '{2'd2, 8'h10, 16'h1111, 1'b1, 16'h1111, 1'b1, 4'd3}   // R3 writeback
    };

    task automatic chk(input logic ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic send(input logic [1:0] op, input logic [7:0] addr,
                        input logic [15:0] data, input logic dv, input logic [2:0] src);
        ring_in_op = op; ring_in_addr = addr; ring_in_data = data;
        ring_in_dv = dv; ring_in_src = src; ring_in_valid = 1'b1;
        while (!ring_in_ready) @(negedge clk);
        @(negedge clk);
        ring_in_valid = 1'b0;
    endtask

    task automatic expect_out(input logic [1:0] op, input logic [7:0] addr,
                              input logic [15:0] data, input logic dv,
                              input logic [2:0] src, input string req);
        int waited = 0;
        while (!ring_out_valid && waited < 12) begin
            @(negedge clk);
            waited++;
        end
        chk(ring_out_valid, req, "ring_out_valid", 32'(ring_out_valid), 32'd1);
        if (ring_out_valid) begin
            chk(ring_out_op == op && ring_out_addr == addr && ring_out_src == src,
                req, "op/addr/src", {19'd0, ring_out_op, ring_out_addr, ring_out_src},
                {19'd0, op, addr, src});
            chk(ring_out_data == data && ring_out_dv == dv, req, "data/dv",
                {15'd0, ring_out_dv, ring_out_data}, {15'd0, dv, data});
            ring_out_ready = 1'b1;
            @(negedge clk);
            ring_out_ready = 1'b0;
        end
    endtask

    task automatic cpu(input logic wr, input logic [7:0] addr, input logic [15:0] wdata);
        cpu_req_write = wr; cpu_req_addr = addr; cpu_req_wdata = wdata;
        cpu_req_valid = 1'b1;
        while (!cpu_req_ready) @(negedge clk);
        @(negedge clk);
        cpu_req_valid = 1'b0;
    endtask

    task automatic expect_rsp(input logic [15:0] data, input string req);
        int waited = 0;
        while (!cpu_rsp_valid && waited < 12) begin
            @(negedge clk);
            waited++;
        end
        chk(cpu_rsp_valid, req, "cpu_rsp_valid", 32'(cpu_rsp_valid), 32'd1);
        chk(cpu_rsp_rdata == data, req, "cpu_rsp_rdata", 32'(cpu_rsp_rdata), 32'(data));
    endtask

    task automatic quiet(input int cycles, input string req);
        logic seen_ring = 1'b0, seen_rsp = 1'b0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            seen_ring |= ring_out_valid;
            seen_rsp  |= cpu_rsp_valid;
        end
        chk(!seen_ring, req, "no ring traffic", 32'(seen_ring), 32'd0);
        chk(!seen_rsp, req, "no cpu response", 32'(seen_rsp), 32'd0);
    endtask

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(cpu_req_ready == 1'b1, "R1", "cpu_req_ready", 32'(cpu_req_ready), 32'd1);
        chk(!ring_out_valid && !cpu_rsp_valid, "R1", "outputs idle",
            {30'd0, ring_out_valid, cpu_rsp_valid}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 idle controller forwards the token
        send(2'd3, 8'h00, 16'h0000, 1'b0, OTHER);
        expect_out(2'd3, 8'h00, 16'h0000, 1'b0, OTHER, "R2");

        // R1 all lines invalid: a load misses and waits for the token
        cpu(1'b0, 8'h10, 16'h0);
        quiet(5, "R2");
        chk(cpu_req_ready == 1'b0, "R10", "cpu_req_ready while held", 32'(cpu_req_ready), 32'd0);
        send(2'd3, 8'h00, 16'h0000, 1'b0, OTHER);
        expect_out(2'd0, 8'h10, 16'h0000, 1'b0, ME, "R2");
        // R4 own read returns with data
        send(2'd0, 8'h10, 16'hAAAA, 1'b1, ME);
        expect_rsp(16'hAAAA, "R4");
        expect_out(2'd2, 8'h10, 16'hAAAA, 1'b1, ME, "R4");
        chk(cpu_req_ready == 1'b0, "R10", "ready in writeback phase", 32'(cpu_req_ready), 32'd0);
        // R8 own writeback returns
        send(2'd2, 8'h10, 16'hAAAA, 1'b1, ME);
        expect_out(2'd3, 8'h00, 16'h0000, 1'b0, ME, "R8");
        chk(cpu_req_ready == 1'b1, "R8", "ready after release", 32'(cpu_req_ready), 32'd1);

        // R9 load hit on Shared
        cpu(1'b0, 8'h10, 16'h0);
        expect_rsp(16'hAAAA, "R9");
        quiet(3, "R9");

        // R5 store to Shared line is a miss
        cpu(1'b1, 8'h10, 16'h1234);
        quiet(4, "R5");
        send(2'd3, 8'h00, 16'h0000, 1'b0, OTHER);
        expect_out(2'd1, 8'h10, 16'h0000, 1'b0, ME, "R5");
        send(2'd1, 8'h10, 16'hAAAA, 1'b1, ME);
        expect_rsp(16'h1234, "R5");
        expect_out(2'd2, 8'h10, 16'h1234, 1'b1, ME, "R5");
        send(2'd2, 8'h10, 16'h1234, 1'b1, ME);
        expect_out(2'd3, 8'h00, 16'h0000, 1'b0, ME, "R8");

        // R9 store hit on Modified, then load back
        cpu(1'b1, 8'h10, 16'h5555);
        expect_rsp(16'h5555, "R9");
        quiet(3, "R9");
        cpu(1'b0, 8'h10, 16'h0);
        expect_rsp(16'h5555, "R9");

        // snoop table (R3, R6, R7, R12)
        for (int i = 0; i < 9; i++) begin
            string tag;
            tag = $sformatf("R%0d vec%0d", VEC[i].req, i);
            send(VEC[i].op, VEC[i].addr, VEC[i].din, VEC[i].dvin, OTHER);
            expect_out(VEC[i].op, VEC[i].addr, VEC[i].exp_data, VEC[i].exp_dv, OTHER, tag);
        end

        // R6 line was invalidated: a load now misses
        cpu(1'b0, 8'h10, 16'h0);
        quiet(5, "R6");
        send(2'd3, 8'h00, 16'h0000, 1'b0, OTHER);
        expect_out(2'd0, 8'h10, 16'h0000, 1'b0, ME, "R6");
        send(2'd0, 8'h10, 16'h3333, 1'b1, ME);
        expect_rsp(16'h3333, "R4");
        expect_out(2'd2, 8'h10, 16'h3333, 1'b1, ME, "R4");
        send(2'd2, 8'h10, 16'h3333, 1'b1, ME);
        expect_out(2'd3, 8'h00, 16'h0000, 1'b0, ME, "R8");

        // R11 back-pressure: eight messages fill both FIFOs, none lost
        for (int i = 0; i < 8; i++) send(2'd0, 8'h40 + 8'(4*i), 16'(i), 1'b0, OTHER);
        repeat (3) @(negedge clk);
        chk(ring_in_ready == 1'b0, "R11", "ring_in_ready when full", 32'(ring_in_ready), 32'd0);
        for (int i = 0; i < 8; i++)
            expect_out(2'd0, 8'h40 + 8'(4*i), 16'(i), 1'b0, OTHER, "R11");
        chk(ring_in_ready == 1'b1, "R11", "ring_in_ready after drain", 32'(ring_in_ready), 32'd1);
        quiet(3, "R11");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule